// File: doc/BRIEF.md
# Scatter-Gather Descriptor Fetch Engine

This block lets one DMA channel work through a chain of buffers without processor help. Software places a linked table of descriptors in memory, writes the address of the first one into the next-link register, and sets the start bit. The engine then repeats three steps. It reads one descriptor a byte at a time through a memory read port. It hands the buffer address and count to the transfer engine with a one-cycle start pulse. It waits for that engine to report that the buffer is finished. After the buffer whose descriptor carries the end-of-list flag, the engine stops and reports that all buffers are done.

During a descriptor fetch the engine is itself the 8-bit I/O target of an ordinary DMA read. Each accepted descriptor byte raises the I/O write strobe. End-of-process marks the last byte, and the external DMA acknowledge stays low. The acknowledge is high only while a buffer is being moved. Bus timing and the data movement are outside this block and are represented only by the start/done handshake.

Top module: `sg_chain_engine`

## Requirements
- R1: After reset the engine is idle. The status register reads 0, the next-link register reads 0, and mrd_req, xfer_start, ext_dack, iow_strobe and eop are all low.
- R2: Writing register address 0 with bit 0 set while the engine is idle starts a fetch. mrd_req rises in the next cycle, and the engine requests the addresses next-link+0 through next-link+7 in ascending order, one byte per accepted request (mrd_req and mrd_ack high in the same cycle).
- R3: Descriptor bytes are little-endian. Bytes 0 to 3 are the buffer address and bytes 4 to 6 are the 24-bit count. Bit 7 of byte 7 is the end-of-list flag, and the other bits of byte 7 are ignored. In the cycle after the last byte is accepted, xfer_start is high for exactly one cycle and carries that address and count on xfer_addr and xfer_count.
- R4: iow_strobe is high in every cycle in which a descriptor byte is accepted. eop is high only on the eighth accepted byte. ext_dack is never high while mrd_req is high.
- R5: When the last descriptor byte is accepted, the next-link register (register address 2, readable) advances by 8.
- R6: ext_dack is high from the cycle after xfer_start until xfer_done is seen. No descriptor request is made in that window. If the descriptor is not flagged end-of-list, mrd_req rises in the cycle after xfer_done.
- R7: After xfer_done for a descriptor flagged end-of-list, the engine goes idle and the status register reads done.
- R8: The status register is at register address 1: bit 0 is active, bit 1 is fetching a descriptor, and bit 2 is all-buffers-done. A read during a fetch gives 3 and a read during a buffer transfer gives 1. The done bit is cleared when a new start is accepted.
- R9: Writing register address 0 with bit 1 set halts the engine. It is idle from the next cycle, with no request and done left clear. If bits 0 and 1 are written together, the halt wins and no run starts.
- R10: While the engine is active, writes to the next-link register are ignored, and so are further start writes. The chain in progress and the next-link value that follows it are unaffected.
- R11: While a request waits for mrd_ack, mrd_req stays high and mrd_addr stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address: 0 command, 1 status, 2 next-link |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| mrd_req | output | 1 | Descriptor byte read request |
| mrd_addr | output | 32 | Descriptor byte address |
| mrd_ack | input | 1 | Memory returns the requested byte this cycle |
| mrd_data | input | 8 | Returned descriptor byte |
| iow_strobe | output | 1 | I/O write strobe for each accepted descriptor byte |
| eop | output | 1 | End-of-process on the last descriptor byte |
| ext_dack | output | 1 | External DMA acknowledge, high while a buffer is moved |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_addr | output | 32 | Buffer address for the transfer engine |
| xfer_count | output | 24 | Buffer count for the transfer engine |
| xfer_done | input | 1 | Transfer engine reports that the buffer is finished |

## Verification
The hardest condition to produce from the ports is a command that lands in the middle of a run. A halt written while descriptor bytes are still arriving, and a second start or next-link write that arrives during a live chain, only matter inside short windows. The bench reaches these windows by writing the registers a fixed number of cycles after the start, while the memory model is inserting varying wait states. Afterwards it reads the status and next-link registers back, and the scoreboard confirms that the chain delivered exactly the buffers listed in the table.

// File: rtl/sgf_pkg.sv
package sgf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_LAUNCH,
      ST_XFER
   } sgf_state_e;

   localparam logic [1:0] RA_CMD  = 2'd0;
   localparam logic [1:0] RA_STAT = 2'd1;
   localparam logic [1:0] RA_LINK = 2'd2;

   localparam int CMD_GO_BIT   = 0;
   localparam int CMD_HALT_BIT = 1;

   localparam int STAT_ACT_BIT   = 0;
   localparam int STAT_FETCH_BIT = 1;
   localparam int STAT_DONE_BIT  = 2;
endpackage

// File: rtl/sgf_regs.sv
module sgf_regs
   import sgf_pkg::*;
#(
   parameter int AW   = 32,
   parameter int STEP = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [1:0]    reg_addr,
   input  logic [AW-1:0] reg_wdata,
   input  logic          active,
   input  logic          fetching,
   input  logic          link_adv,
   input  logic          done_set,
   output logic          go,
   output logic          halt,
   output logic [AW-1:0] link,
   output logic [AW-1:0] reg_rdata
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   logic          cmd_wr;
   logic          done_q;
   logic [AW-1:0] link_q;

   assign cmd_wr = reg_wr && (reg_addr == RA_CMD);
   assign halt   = cmd_wr && reg_wdata[CMD_HALT_BIT];
   assign go     = cmd_wr && reg_wdata[CMD_GO_BIT] && !reg_wdata[CMD_HALT_BIT] && !active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q <= '0;
      end else if (reg_wr && (reg_addr == RA_LINK) && !active) begin
         link_q <= reg_wdata;
      end else if (link_adv) begin
         link_q <= link_q + STEP_V;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else if (go) begin
         done_q <= 1'b0;
      end else if (done_set) begin
         done_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_STAT: begin
            reg_rdata[STAT_ACT_BIT]   = active;
            reg_rdata[STAT_FETCH_BIT] = fetching;
            reg_rdata[STAT_DONE_BIT]  = done_q;
         end
         RA_LINK: reg_rdata = link_q;
         default: reg_rdata = '0;
      endcase
   end

   assign link = link_q;
endmodule

// File: rtl/sgf_asm.sv
module sgf_asm #(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 24,
   parameter int EOL_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetching,
   input  logic              capture,
   input  logic [7:0]        byte_in,
   input  logic [ADDR_W-1:0] link,
   output logic              last,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [CNT_W-1:0]  buf_cnt,
   output logic              eol
);
   localparam int NBYTES = ADDR_W / 8 + CNT_W / 8 + 1;
   localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

   logic [IDX_W-1:0]    idx_q;
   logic [NBYTES*8-1:0] flat;

   always_ff @(posedge clk) begin
      if (!rst_n || !fetching) begin
         idx_q <= '0;
      end else if (capture) begin
         idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      logic [7:0] b_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            b_q <= '0;
         end else if (capture && (idx_q == IDX_W'(g))) begin
            b_q <= byte_in;
         end
      end
      assign flat[g*8 +: 8] = b_q;
   end

   assign last      = fetching && (idx_q == LAST_IDX);
   assign byte_addr = link + ADDR_W'(idx_q);
   assign buf_addr  = flat[ADDR_W-1:0];
   assign buf_cnt   = flat[ADDR_W +: CNT_W];
   assign eol       = flat[ADDR_W + CNT_W + EOL_BIT];
endmodule

// File: rtl/sgf_seq.sv
module sgf_seq
   import sgf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic halt,
   input  logic mrd_ack,
   input  logic last,
   input  logic eol,
   input  logic xfer_done,
   output logic mrd_req,
   output logic capture,
   output logic fetch_end,
   output logic xfer_start,
   output logic ext_dack,
   output logic done_set,
   output logic active,
   output logic fetching
);
   sgf_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:   if (go) st_d = ST_FETCH;
         ST_FETCH:  if (halt) st_d = ST_IDLE;
                    else if (mrd_ack && last) st_d = ST_LAUNCH;
         ST_LAUNCH: st_d = halt ? ST_IDLE : ST_XFER;
         ST_XFER:   if (halt) st_d = ST_IDLE;
                    else if (xfer_done) st_d = eol ? ST_IDLE : ST_FETCH;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign fetching   = (st_q == ST_FETCH);
   assign mrd_req    = fetching;
   assign capture    = fetching && mrd_ack;
   assign fetch_end  = capture && last && !halt;
   assign xfer_start = (st_q == ST_LAUNCH);
   assign ext_dack   = (st_q == ST_XFER);
   assign done_set   = (st_q == ST_XFER) && xfer_done && eol && !halt;
   assign active     = (st_q != ST_IDLE);
endmodule

// File: rtl/sg_chain_engine.sv
module sg_chain_engine #(
   parameter int ADDR_W  = 32,
   parameter int CNT_W   = 24,
   parameter int EOL_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              mrd_req,
   output logic [ADDR_W-1:0] mrd_addr,
   input  logic              mrd_ack,
   input  logic [7:0]        mrd_data,
   output logic              iow_strobe,
   output logic              eop,
   output logic              ext_dack,
   output logic              xfer_start,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [CNT_W-1:0]  xfer_count,
   input  logic              xfer_done
);
   localparam int DESC_BYTES = ADDR_W / 8 + CNT_W / 8 + 1;

   if (ADDR_W % 8 != 0 || ADDR_W < 8) begin : g_bad_addr_w
      $error("ADDR_W must be a positive multiple of 8");
   end
   if (CNT_W % 8 != 0 || CNT_W < 8) begin : g_bad_cnt_w
      $error("CNT_W must be a positive multiple of 8");
   end
   if (EOL_BIT < 0 || EOL_BIT > 7) begin : g_bad_eol
      $error("EOL_BIT must select a bit of the flag byte");
   end

   logic              go, halt, active, fetching;
   logic              capture, fetch_end, done_set;
   logic              last, eol;
   logic [ADDR_W-1:0] link_q;

   sgf_regs #(.AW(ADDR_W), .STEP(DESC_BYTES)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .active    (active),
      .fetching  (fetching),
      .link_adv  (fetch_end),
      .done_set  (done_set),
      .go        (go),
      .halt      (halt),
      .link      (link_q),
      .reg_rdata (reg_rdata)
   );

   sgf_asm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EOL_BIT(EOL_BIT)) asm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetching  (fetching),
      .capture   (capture),
      .byte_in   (mrd_data),
      .link      (link_q),
      .last      (last),
      .byte_addr (mrd_addr),
      .buf_addr  (xfer_addr),
      .buf_cnt   (xfer_count),
      .eol       (eol)
   );

   sgf_seq seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .halt       (halt),
      .mrd_ack    (mrd_ack),
      .last       (last),
      .eol        (eol),
      .xfer_done  (xfer_done),
      .mrd_req    (mrd_req),
      .capture    (capture),
      .fetch_end  (fetch_end),
      .xfer_start (xfer_start),
      .ext_dack   (ext_dack),
      .done_set   (done_set),
      .active     (active),
      .fetching   (fetching)
   );

   assign iow_strobe = capture;
   assign eop        = fetch_end;
endmodule

// File: rtl/sgf_chk.sv
module sgf_chk #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic [ADDR_W-1:0] reg_wdata,
   input logic              mrd_req,
   input logic              mrd_ack,
   input logic [ADDR_W-1:0] mrd_addr,
   input logic              iow_strobe,
   input logic              eop,
   input logic              ext_dack,
   input logic              xfer_start,
   input logic [ADDR_W-1:0] link
);
   logic halt_wr;
   assign halt_wr = reg_wr && (reg_addr == 2'd0) && reg_wdata[1];

   // R4
   eop_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eop |-> iow_strobe);

   // R4
   no_dack_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mrd_req |-> !ext_dack);

   // R3
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);

   // R6
   dack_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start && !halt_wr) |=> ext_dack);

   // R11
   hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mrd_req && !mrd_ack && !halt_wr) |=> (mrd_req && $stable(mrd_addr)));

   // R5
   link_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eop |=> (link == $past(link) + ADDR_W'(STEP)));
endmodule

bind sg_chain_engine sgf_chk #(.ADDR_W(ADDR_W), .STEP(DESC_BYTES)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .mrd_req    (mrd_req),
   .mrd_ack    (mrd_ack),
   .mrd_addr   (mrd_addr),
   .iow_strobe (iow_strobe),
   .eop        (eop),
   .ext_dack   (ext_dack),
   .xfer_start (xfer_start),
   .link       (link_q)
);

// File: tb/sg_chain_engine_tb_top.sv
module sg_chain_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mrd_req, iow_strobe, eop, ext_dack, xfer_start;
   logic [31:0] mrd_addr, xfer_addr;
   logic [23:0] xfer_count;
   logic        mrd_ack = 1'b0;
   logic [7:0]  mrd_data = '0;
   logic        xfer_done = 1'b0;

   always #2 clk = ~clk;

   sg_chain_engine dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mrd_req(mrd_req),
      .mrd_addr(mrd_addr), .mrd_ack(mrd_ack), .mrd_data(mrd_data),
      .iow_strobe(iow_strobe), .eop(eop), .ext_dack(ext_dack),
      .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_count(xfer_count),
      .xfer_done(xfer_done)
   );

   typedef struct {
      logic [31:0] a;
      logic [23:0] c;
      bit          e;
   } item_t;

   item_t       exp_q[$];
   logic [7:0]  mem [0:255];
   int          checks = 0;
   int          errors = 0;
   logic [31:0] mon_link = '0;
   int          mon_byte = 0;
   bit          in_xfer = 0;
   bit          exp_req = 0;
   bit          last_eol = 0;
   bit          prev_wait = 0;
   logic [31:0] prev_addr = '0;

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic put_desc(input int base, input logic [31:0] a, input logic [23:0] c,
                           input logic [7:0] flag);
      item_t it;
      for (int i = 0; i < 4; i++) mem[base + i] = a[i*8 +: 8];
      for (int i = 0; i < 3; i++) mem[base + 4 + i] = c[i*8 +: 8];
      mem[base + 7] = flag;
      it.a = a; it.c = c; it.e = flag[7];
      exp_q.push_back(it);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_done();
      logic [31:0] s;
      for (int i = 0; i < 3000; i++) begin
         reg_read(2'd1, s);
         if (s[2]) break;
      end
   endtask

   // memory model with varying wait states
   int wcnt = 0;
   int want = 0;
   always @(negedge clk) begin
      if (mrd_req) begin
         if (wcnt >= want) begin
            mrd_ack  <= 1'b1;
            mrd_data <= mem[mrd_addr[7:0]];
            wcnt     = 0;
            want     = (want + 1) % 3;
         end else begin
            mrd_ack <= 1'b0;
            wcnt++;
         end
      end else begin
         mrd_ack <= 1'b0;
         wcnt    = 0;
      end
   end

   // transfer engine model: done six cycles after start
   int xcnt = 0;
   always @(negedge clk) begin
      xfer_done <= 1'b0;
      if (xfer_start) xcnt = 6;
      else if (xcnt > 0) begin
         xcnt--;
         if (xcnt == 0) xfer_done <= 1'b1;
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (exp_req) begin
            check_eq("R6 fetch resumes after done", {31'd0, mrd_req}, 32'd1);
            exp_req = 0;
         end
         if (mrd_req && ext_dack) check_eq("R4 dack during fetch", 32'd1, 32'd0);
         if (prev_wait && mrd_req)
            check_eq("R11 address held while waiting", mrd_addr, prev_addr);
         prev_wait = mrd_req && !mrd_ack;
         prev_addr = mrd_addr;
         if (mrd_req && mrd_ack) begin
            check_eq("R2 byte address order", mrd_addr, mon_link + 32'(mon_byte));
            check_eq("R4 strobe on byte", {31'd0, iow_strobe}, 32'd1);
            check_eq("R4 eop on last byte only", {31'd0, eop}, {31'd0, mon_byte == 7});
            mon_byte++;
            if (mon_byte == 8) begin
               mon_byte = 0;
               mon_link = mon_link + 32'd8;
            end
         end else begin
            if (iow_strobe || eop) check_eq("R4 strobe without byte", 32'd1, 32'd0);
         end
         if (in_xfer) begin
            check_eq("R6 dack held during buffer", {31'd0, ext_dack}, 32'd1);
            if (mrd_req) check_eq("R6 request during buffer", 32'd1, 32'd0);
            if (xfer_done) begin
               in_xfer = 0;
               exp_req = !last_eol;
            end
         end
         if (xfer_start) begin
            if (exp_q.size() == 0) begin
               check_eq("R3 unexpected buffer start", 32'd1, 32'd0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               check_eq("R3 buffer address", xfer_addr, it.a);
               check_eq("R3 buffer count", {8'd0, xfer_count}, {8'd0, it.c});
               check_eq("R6 no dack in start cycle", {31'd0, ext_dack}, 32'd0);
               last_eol = it.e;
               in_xfer  = 1;
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check_eq("R1 mrd_req", {31'd0, mrd_req}, 32'd0);
      check_eq("R1 xfer_start", {31'd0, xfer_start}, 32'd0);
      check_eq("R1 ext_dack", {31'd0, ext_dack}, 32'd0);
      check_eq("R1 strobes", {30'd0, iow_strobe, eop}, 32'd0);
      reg_read(2'd1, d); check_eq("R1 status", d, 32'd0);
      reg_read(2'd2, d); check_eq("R1 next-link", d, 32'd0);

      // chain of three at 0x40; flag byte 0x7F must not end the list (R3)
      put_desc(8'h40, 32'h1000_0010, 24'h000123, 8'h7F);
      put_desc(8'h48, 32'hABCD_EF01, 24'hFFFFFF, 8'h00);
      put_desc(8'h50, 32'h55AA_33CC, 24'h000001, 8'h80);
      reg_write(2'd2, 32'h40);
      reg_read(2'd2, d); check_eq("R5 next-link write", d, 32'h40);
      mon_link = 32'h40; mon_byte = 0;
      reg_write(2'd0, 32'h1);
      reg_read(2'd1, d); check_eq("R8 status while fetching", d, 32'd3);
      reg_write(2'd2, 32'hF0);   // R10 ignored
      reg_write(2'd0, 32'h1);    // R10 ignored
      for (int i = 0; i < 200 && !ext_dack; i++) @(negedge clk);
      reg_read(2'd1, d); check_eq("R8 status during buffer", d, 32'd1);
      wait_done();
      reg_read(2'd1, d); check_eq("R7 done after end-of-list", d, 32'd4);
      reg_read(2'd2, d); check_eq("R5 R10 next-link after chain", d, 32'h58);
      check_eq("R3 R10 all buffers served", 32'(exp_q.size()), 32'd0);

      // R9 halt during fetch
      put_desc(8'h80, 32'h2222_4444, 24'h000800, 8'h80);
      exp_q.delete();
      reg_write(2'd2, 32'h80);
      mon_link = 32'h80; mon_byte = 0;
      reg_write(2'd0, 32'h1);
      reg_read(2'd1, d); check_eq("R8 done cleared by start", d, 32'd3);
      reg_write(2'd0, 32'h2);
      #1;
      check_eq("R9 no request after halt", {31'd0, mrd_req}, 32'd0);
      reg_read(2'd1, d); check_eq("R9 idle after halt", d, 32'd0);
      reg_read(2'd2, d); check_eq("R9 next-link kept", d, 32'h80);

      // R9 halt and start together
      reg_write(2'd0, 32'h3);
      repeat (2) @(negedge clk);
      #1;
      check_eq("R9 halt wins request", {31'd0, mrd_req}, 32'd0);
      reg_read(2'd1, d); check_eq("R9 halt wins status", d, 32'd0);

      // single-descriptor chain
      put_desc(8'h80, 32'h2222_4444, 24'h000800, 8'h80);
      mon_link = 32'h80; mon_byte = 0;
      reg_write(2'd0, 32'h1);
      wait_done();
      reg_read(2'd1, d); check_eq("R7 done single", d, 32'd4);
      reg_read(2'd2, d); check_eq("R5 next-link single", d, 32'h88);
      check_eq("R3 single buffer served", 32'(exp_q.size()), 32'd0);
      repeat (10) @(negedge clk);
      #1;
      check_eq("R7 stays idle", {30'd0, mrd_req, ext_dack}, 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule